// File: doc/BRIEF.md
# Processor Bus Cycle Master

This block is the master side of a synchronous, processor-style external bus. A local client hands it one request at a time: an address, write data, a read/write flag and a burst flag. The block runs that request on the bus as a single read, a single write, or a four-beat burst read. Every cycle opens with one address phase, in which the active-low address strobe is low for exactly one clock. It then stays in a data phase until the memory side pulls the active-low ready line low. Each clock in which ready stays high adds one wait state.

Read data returns to the client as a one-clock valid pulse per beat. A done pulse marks the end of each cycle. Between cycles the bus sits idle. Another master can take the bus by raising hold. The block lets the running cycle finish, answers with hold-acknowledge, and switches off the output enables of its address, control and data drivers. Those drivers come back only after hold has been released.

Top module: `bus_cycle_master`

## Requirements
- R1: In the address phase the address strobe `bus_ads_n` is low for exactly one clock. `bus_addr` carries the cycle address from that clock through the last data-phase clock.
- R2: After the address phase the block stays in the data phase until it samples `bus_rdy_n` low at a clock edge. A cycle of B beats with W wait states per beat ends with `done` on the (2 + B*(W+1))-th clock after the edge that accepted the request.
- R3: `bus_wr` is 1 for a write and 0 for a read, and it holds one value for the whole cycle.
- R4: A read requested with the burst flag drives `bus_cache_n` low for the whole cycle and transfers four beats. One beat completes at each data-phase edge where ready is low.
- R5: Burst beat addresses step by 4 bytes (the 32-bit data width) and wrap inside the aligned 16-byte block. For example, a start at 0x208 runs 0x208, 0x20C, 0x200, 0x204.
- R6: While idle, `bus_ads_n` is high and `bus_addr` is zero. A low `bus_rdy_n` outside the data phase has no effect on the cycle.
- R7: Hold raised during a cycle lets that cycle complete. The block then raises `hlda` and holds `bus_oe` and `bus_data_oe` low until hold falls.
- R8: `hlda` falls one clock after hold is sampled low. `bus_oe` is high again from that clock, so it is re-enabled before any address phase.
- R9: On a write, `bus_data_oe` is high and `bus_wdata` carries the write data from the address phase through the data-phase clock in which ready is seen. It is low otherwise.
- R10: On a read, each beat's `bus_rdata` is captured at the edge where ready is low. It appears on `rd_data`, with `rd_valid` high for one clock, on the clock after that edge.
- R11: `done` is a one-clock pulse on the clock after the final beat's ready edge.
- R12: `req_busy` is high whenever the bus is not idle or hold is high. A request is accepted only when `req_valid` is high and `req_busy` is low, and hold wins over a waiting request.
- R13: The burst flag on a write has no effect. The write is a single beat and `bus_cache_n` stays high.
- R14: After reset the bus is idle: `bus_ads_n` high, `bus_addr` zero, `bus_oe` high, and `hlda`, `req_busy`, `rd_valid` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Ask for a four-beat burst (reads only) |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_busy | output | 1 | Bus not idle or hold pending; requests not taken |
| bus_addr | output | ADDR_W | Bus address |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_wr | output | 1 | Write/read select |
| bus_cache_n | output | 1 | Active-low burst (cacheable) indicator |
| bus_oe | output | 1 | Output enable for address and control drivers |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_data_oe | output | 1 | Output enable for the data drivers |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low ready from the memory side |
| hold | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Hold acknowledge; drivers are floated |
| rd_valid | output | 1 | One-clock pulse per captured read beat |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
Single reads run with zero and with three wait states, so the cycle length must follow the ready line rather than a fixed count. A single write checks the data-enable window, and a write carrying the burst flag must still finish in one beat. One burst read starts on an aligned address and one starts mid-block, which separates a true wrap from a plain increment. Ready is also pulled low outside the data phase, and hold is raised both in the middle of a burst and while a request waits. These runs show whether the handover waits for the cycle boundary and whether hold wins over a pending request.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HELD = 2'd3
    } bus_state_e;
endpackage

// File: rtl/bcm_beat_addr.sv
// Next beat address: increments the beat index field, wraps within the aligned block.
module bcm_beat_addr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    localparam int LSB   = $clog2(DATA_W / 8);
    localparam int IDX_W = $clog2(BEATS);

    generate
        if (IDX_W > 0) begin : g_wrap
            logic [IDX_W-1:0] idx;
            always_comb begin
                idx = cur_addr[LSB +: IDX_W];
                nxt_addr = cur_addr;
                nxt_addr[LSB +: IDX_W] = idx + IDX_W'(1);
            end
        end else begin : g_single
            assign nxt_addr = cur_addr;
        end
    endgenerate
endmodule

// File: rtl/bcm_pin_decode.sv
// Pin values decoded from the registered bus state.
module bcm_pin_decode
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  bus_state_e        st,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              brst,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_ads_n,
    output logic              pin_wr,
    output logic              pin_cache_n,
    output logic              pin_oe,
    output logic [DATA_W-1:0] pin_wdata,
    output logic              pin_data_oe,
    output logic              pin_hlda
);
    logic in_cyc;

    always_comb begin
        in_cyc      = (st == ST_ADDR) || (st == ST_DATA);
        pin_ads_n   = (st != ST_ADDR);
        pin_addr    = in_cyc ? addr : '0;
        pin_wr      = in_cyc & wr;
        pin_cache_n = ~(in_cyc & brst);
        pin_oe      = (st != ST_HELD);
        pin_hlda    = (st == ST_HELD);
        pin_data_oe = in_cyc & wr;
        pin_wdata   = pin_data_oe ? wdata : '0;
    end
endmodule

// File: rtl/bcm_rd_capture.sv
// Registers read beats and the end-of-cycle pulse.
module bcm_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_take,
    input  logic              is_read,
    input  logic              is_last,
    input  logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic              valid_d, valid_q;
    logic              done_d, done_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        valid_d = beat_take & is_read;
        done_d  = beat_take & is_last;
        data_d  = (beat_take & is_read) ? rdata : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            done_q  <= done_d;
            data_q  <= data_d;
        end
    end

    assign rd_valid = valid_q;
    assign done     = done_q;
    assign rd_data  = data_q;
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ads_n,
    output logic              bus_wr,
    output logic              bus_cache_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rdy_n,
    input  logic              hold,
    output logic              hlda,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        bus_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              brst;
        logic [BEAT_W-1:0] beat;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic [ADDR_W-1:0] addr_next;
    logic              beat_take;
    logic              beat_last;
    bus_state_e        cur_st;

    assign cur_st = seq_q.st;

    bcm_beat_addr #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .BEATS (BEATS)
    ) u_beat_addr (
        .cur_addr(seq_q.addr),
        .nxt_addr(addr_next)
    );

    always_comb begin
        seq_d     = seq_q;
        beat_last = ~seq_q.brst || (seq_q.beat == LAST_BEAT);
        beat_take = (seq_q.st == ST_DATA) && ~bus_rdy_n;
        req_busy  = (seq_q.st != ST_IDLE) || hold;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (hold) begin
                    seq_d.st = ST_HELD;
                end else if (req_valid) begin
                    seq_d.st    = ST_ADDR;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.wr    = req_write;
                    seq_d.brst  = req_burst & ~req_write;
                    seq_d.beat  = '0;
                end
            end
            ST_ADDR: seq_d.st = ST_DATA;
            ST_DATA: begin
                if (beat_take) begin
                    if (beat_last) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.beat = seq_q.beat + BEAT_W'(1);
                        seq_d.addr = addr_next;
                    end
                end
            end
            ST_HELD: begin
                if (!hold) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, wdata: '0, wr: 1'b0, brst: 1'b0, beat: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    bcm_pin_decode #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .st         (seq_q.st),
        .addr       (seq_q.addr),
        .wdata      (seq_q.wdata),
        .wr         (seq_q.wr),
        .brst       (seq_q.brst),
        .pin_addr   (bus_addr),
        .pin_ads_n  (bus_ads_n),
        .pin_wr     (bus_wr),
        .pin_cache_n(bus_cache_n),
        .pin_oe     (bus_oe),
        .pin_wdata  (bus_wdata),
        .pin_data_oe(bus_data_oe),
        .pin_hlda   (hlda)
    );

    bcm_rd_capture #(
        .DATA_W(DATA_W)
    ) u_rd_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_take(beat_take),
        .is_read  (~seq_q.wr),
        .is_last  (beat_last),
        .rdata    (bus_rdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .done     (done)
    );
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        state,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ads_n,
    input logic              bus_wr,
    input logic              bus_cache_n,
    input logic              bus_oe,
    input logic              bus_data_oe,
    input logic              bus_rdy_n,
    input logic              hold,
    input logic              hlda,
    input logic              req_busy,
    input logic              rd_valid,
    input logic              done
);
    p_strobe_one_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    p_wr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> $stable(bus_wr));

    p_burst_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cache_n |-> !bus_wr);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bus_ads_n && bus_addr == '0));

    p_float_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !bus_data_oe));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> (!hlda && bus_oe));

    p_rd_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!bus_rdy_n && state == ST_DATA));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_outside_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> req_busy);
endmodule

bind bus_cycle_master bcm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (cur_st),
    .bus_addr   (bus_addr),
    .bus_ads_n  (bus_ads_n),
    .bus_wr     (bus_wr),
    .bus_cache_n(bus_cache_n),
    .bus_oe     (bus_oe),
    .bus_data_oe(bus_data_oe),
    .bus_rdy_n  (bus_rdy_n),
    .hold       (hold),
    .hlda       (hlda),
    .req_busy   (req_busy),
    .rd_valid   (rd_valid),
    .done       (done)
);

// File: tb/bus_cycle_master_tb.sv
`timescale 1ns/1ps
module bus_cycle_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_busy;
    logic [31:0] bus_addr, bus_wdata, rd_data;
    logic [31:0] bus_rdata = '0;
    logic        bus_ads_n, bus_wr, bus_cache_n, bus_oe, bus_data_oe;
    logic        bus_rdy_n = 1'b1, hold = 1'b0;
    logic        hlda, rd_valid, done;

    int checks = 0, errors = 0;
    int wait_cfg = 0, wc = 0;
    bit noise = 0, finished = 0;

    // reference model state: 0 idle, 1 address phase, 2 data phase, 3 held
    int          m_ph = 0, m_beat = 0;
    logic [31:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
    bit          m_wr = 0, m_burst = 0, m_rv = 0, m_done = 0, m_acc = 0;

    always #10 clk = ~clk;

    bus_cycle_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
        .bus_addr(bus_addr), .bus_ads_n(bus_ads_n), .bus_wr(bus_wr),
        .bus_cache_n(bus_cache_n), .bus_oe(bus_oe), .bus_wdata(bus_wdata),
        .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n),
        .hold(hold), .hlda(hlda), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        m_acc = 0; m_rv = 0; m_done = 0;
        if (!rst_n) begin
            m_ph = 0; m_beat = 0; m_addr = '0; m_wr = 0; m_burst = 0;
            return;
        end
        case (m_ph)
            0: if (hold) m_ph = 3;
               else if (req_valid) begin
                   m_ph = 1; m_addr = req_addr; m_wdata = req_wdata;
                   m_wr = req_write; m_burst = req_burst && !req_write;
                   m_beat = 0; m_acc = 1;
               end
            1: m_ph = 2;
            2: if (!bus_rdy_n) begin
                   if (!m_wr) begin m_rv = 1; m_rdata = mem_word(m_addr); end
                   if (!m_burst || m_beat == 3) begin
                       m_done = 1; m_ph = 0;
                   end else begin
                       m_beat++;
                       m_addr = (m_addr & ~32'hF) | ((m_addr + 32'd4) & 32'hF);
                   end
               end
            default: if (!hold) m_ph = 0;
        endcase
    endtask

    task automatic compare_and_respond();
        bit cyc;
        cyc = (m_ph == 1) || (m_ph == 2);
        if (rst_n) begin
            chk(m_ph == 0 ? "R6" : "R1", "ads_n", 32'(bus_ads_n), 32'(m_ph != 1));
            chk(m_ph == 0 ? "R6" : ((m_ph == 2 && m_beat > 0) ? "R5" : "R1"),
                "addr", bus_addr, cyc ? m_addr : 32'h0);
            chk("R3", "wr", 32'(bus_wr), 32'(cyc && m_wr));
            chk(m_wr ? "R13" : "R4", "cache_n", 32'(bus_cache_n), 32'(!(cyc && m_burst)));
            chk("R9", "data_oe", 32'(bus_data_oe), 32'(cyc && m_wr));
            if (cyc && m_wr) chk("R9", "wdata", bus_wdata, m_wdata);
            chk("R7", "hlda", 32'(hlda), 32'(m_ph == 3));
            chk("R8", "bus_oe", 32'(bus_oe), 32'(m_ph != 3));
            chk("R12", "busy", 32'(req_busy), 32'(m_ph != 0 || hold));
            chk("R10", "rd_valid", 32'(rd_valid), 32'(m_rv));
            if (m_rv) chk("R10", "rd_data", rd_data, m_rdata);
            chk("R11", "done", 32'(done), 32'(m_done));
        end
        bus_rdata = mem_word(bus_addr);
        if (m_ph == 2) begin
            if (wc < wait_cfg) begin bus_rdy_n = 1'b1; wc++; end
            else begin bus_rdy_n = 1'b0; wc = 0; end
        end else begin
            wc = 0;
            bus_rdy_n = noise ? 1'b0 : 1'b1;
        end
    endtask

    initial forever begin @(posedge clk); model_step(); end
    initial forever begin @(negedge clk); compare_and_respond(); end

    task automatic issue(input logic [31:0] a, input bit wr, input bit br,
                         input logic [31:0] wd, input int w, input int beats,
                         input string tag);
        int n;
        wait_cfg = w;
        req_addr = a; req_write = wr; req_burst = br; req_wdata = wd;
        req_valid = 1'b1;
        do begin @(posedge clk); #1; end while (!m_acc);
        req_valid = 1'b0;
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!done && n < 200);
        chk(tag, "cycle length", 32'(n), 32'(2 + beats * (w + 1)));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        // R14: reset state at the pins
        chk("R14", "ads_n", 32'(bus_ads_n), 32'd1);
        chk("R14", "addr", bus_addr, 32'h0);
        chk("R14", "bus_oe", 32'(bus_oe), 32'd1);
        chk("R14", "hlda", 32'(hlda), 32'd0);
        chk("R14", "busy", 32'(req_busy), 32'd0);
        chk("R14", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R14", "done", 32'(done), 32'd0);

        issue(32'h0000_0040, 0, 0, 32'h0, 0, 1, "R2");              // single read, no waits
        issue(32'h0000_0044, 0, 0, 32'h0, 3, 1, "R2");              // single read, 3 waits
        issue(32'h0000_0080, 1, 0, 32'hCAFE_0001, 1, 1, "R9");      // single write
        issue(32'h0000_0100, 0, 1, 32'h0, 0, 4, "R4");              // aligned burst
        issue(32'h0000_0208, 0, 1, 32'h0, 2, 4, "R5");              // wrapping burst
        issue(32'h0000_0300, 1, 1, 32'hBEEF_0002, 0, 1, "R13");     // write with burst flag
        noise = 1;                                                  // R6: stray ready outside data phase
        repeat (3) @(negedge clk);
        issue(32'h0000_0404, 0, 0, 32'h0, 2, 1, "R6");
        noise = 0;
        // R7: hold raised mid-burst, burst still completes
        fork
            issue(32'h0000_050C, 0, 1, 32'h0, 1, 4, "R7");
            begin repeat (4) @(negedge clk); #2 hold = 1'b1; end
        join
        repeat (3) @(negedge clk);
        // R12 and R8: request waits while held, then runs after release
        fork
            issue(32'h0000_0600, 1, 0, 32'h1234_5678, 0, 1, "R12");
            begin repeat (5) @(negedge clk); #2 hold = 1'b0; end
        join
        // back-to-back reads
        issue(32'h0000_0704, 0, 1, 32'h0, 0, 4, "R10");
        issue(32'h0000_0710, 0, 0, 32'h0, 1, 1, "R11");
        repeat (4) @(negedge clk);
        summary();
    end
endmodule